// File: doc/BRIEF.md
# Super I/O Configuration Index/Data Port

This block is the configuration front end of a Super I/O controller. It occupies two adjacent byte addresses on a simple I/O bus. The lower address selects a configuration index and the upper address reads or writes the register that index selects. The configuration lives in a 256-entry byte register file. Slot 0 of that file is the index pointer itself, so the index and the data share one storage array.

After reset every register clears. A small sequencer then replays the power-on defaults through the same index/data write path the bus uses, finishing with an index write of 0. While that replay runs the block drops bus traffic. A decode-enable input, driven by a bit of the ISA bridge configuration, gates all bus access. The function-select byte and the four base-address bytes (floppy, parallel, two serial ports) are driven out continuously, both raw and decoded into 10-bit I/O addresses for the peripherals.

Top module: `sio_cfg_port`

## Requirements
- R1: A write to offset 0 (address 0x3F0) stores the byte as the current index, and a read at offset 0 returns the current index.
- R2: A write to offset 1 (address 0x3F1) stores the byte in the register selected by the current index, and a read at offset 1 returns that register.
- R3: A read at offset 1 while the index is 0x00 returns 0x00.
- R4: Bus writes to the read-only indices 0xE0 (device ID) and 0xE1 (revision) leave those registers unchanged.
- R5: After reset the block spends exactly 13 cycles (init_busy high) loading defaults: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE, all other registers 0x00. During those cycles bus writes are ignored and bus reads return 0xFF.
- R6: When the default load finishes, the index is 0x00.
- R7: While decode_en is low, reads return 0xFF and writes have no effect.
- R8: Accesses to addresses other than 0x3F0 and 0x3F1 return 0xFF on read and have no effect on write.
- R9: Each decoded base-address output equals its register byte shifted left by 2 (for example 0xFE gives 0x3F8), and the raw outputs show registers 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8.
- R10: Indices with no defined function still store a written byte and return it on a later read.
- R11: io_rdata updates on the clock edge that samples io_rd high and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decode_en | input | 1 | Port decode enable from the bridge configuration |
| io_addr | input | 16 | I/O bus byte address |
| io_wr | input | 1 | Byte write strobe, one cycle |
| io_rd | input | 1 | Byte read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| init_busy | output | 1 | High while defaults are being loaded |
| func_sel | output | 8 | Function-select register byte |
| fdc_base_reg | output | 8 | Floppy base register byte |
| lpt_base_reg | output | 8 | Parallel base register byte |
| uart_a_base_reg | output | 8 | Serial 1 base register byte |
| uart_b_base_reg | output | 8 | Serial 2 base register byte |
| fdc_io_base | output | 10 | Decoded floppy I/O base |
| lpt_io_base | output | 10 | Decoded parallel I/O base |
| uart_a_io_base | output | 10 | Decoded serial 1 I/O base |
| uart_b_io_base | output | 10 | Decoded serial 2 I/O base |

## Verification
The hardest situation to reach from the ports is bus traffic that lands inside the 13-cycle default replay. Whether that traffic is blocked only shows once the replay ends, because the sequencer's own final index write would hide a stray index write. The bench therefore releases reset and drives an index write and a read while init_busy is still high. It then checks that the read returned 0xFF and that a later data write lands in register 0 and not in the stray index. A second awkward case is the shared slot 0: the bench writes data while the index is 0 and checks that the write moves the index.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned NUM_DEFAULTS = 6;
  localparam int unsigned BASE_SHIFT   = 2;
  localparam int unsigned IOB_W        = BYTE_W + BASE_SHIFT;

  localparam logic [BYTE_W-1:0] IDX_DEV_ID   = 8'hE0;
  localparam logic [BYTE_W-1:0] IDX_DEV_REV  = 8'hE1;
  localparam logic [BYTE_W-1:0] IDX_FUNC_SEL = 8'hE2;
  localparam logic [BYTE_W-1:0] IDX_FDC      = 8'hE3;
  localparam logic [BYTE_W-1:0] IDX_LPT      = 8'hE6;
  localparam logic [BYTE_W-1:0] IDX_UART_A   = 8'hE7;
  localparam logic [BYTE_W-1:0] IDX_UART_B   = 8'hE8;

  // one write request into the register file
  typedef struct packed {
    logic              en;
    logic              ofs;   // 0: index slot, 1: indexed register
    logic              priv;  // init path, bypasses read-only filter
    logic [BYTE_W-1:0] data;
  } cfg_wr_t;

  function automatic logic [BYTE_W-1:0] default_idx(input int unsigned n);
    case (n)
      0:       default_idx = IDX_DEV_ID;
      1:       default_idx = IDX_FUNC_SEL;
      2:       default_idx = IDX_FDC;
      3:       default_idx = IDX_LPT;
      4:       default_idx = IDX_UART_A;
      default: default_idx = IDX_UART_B;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] default_val(input int unsigned n);
    case (n)
      0:       default_val = 8'h3C;
      1:       default_val = 8'h03;
      2:       default_val = 8'hFC;
      3:       default_val = 8'hDE;
      4:       default_val = 8'hFE;
      default: default_val = 8'hBE;
    endcase
  endfunction

  function automatic logic is_read_only(input logic [BYTE_W-1:0] idx);
    is_read_only = (idx == IDX_DEV_ID) || (idx == IDX_DEV_REV);
  endfunction

  function automatic logic [IOB_W-1:0] base_from_reg(input logic [BYTE_W-1:0] v);
    base_from_reg = {v, {BASE_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/sio_cfg_bus_dec.sv
module sio_cfg_bus_dec #(
  parameter int unsigned      ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h03F0
) (
  input  logic [ADDR_W-1:0] io_addr,
  output logic              hit,
  output logic              ofs
);
  // the port spans two bytes: everything above bit 0 must match
  assign hit = (io_addr[ADDR_W-1:1] == IO_BASE[ADDR_W-1:1]);
  assign ofs = io_addr[0];
endmodule

// File: rtl/sio_cfg_init_seq.sv
module sio_cfg_init_seq
  import sio_cfg_pkg::*;
#(
  parameter int unsigned NUM_ITEMS = NUM_DEFAULTS
) (
  input  logic    clk,
  input  logic    rst_n,
  output logic    busy,
  output cfg_wr_t wr
);
  // two writes per default (index, data) plus a final index-zero write
  localparam int unsigned STEPS = 2 * NUM_ITEMS + 1;
  localparam int unsigned CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0] step_q;
  logic          busy_q;
  logic          last_step;
  int unsigned   item;

  assign last_step = (step_q == LAST);
  assign item      = int'(step_q >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      step_q <= step_q + 1'b1;
      if (last_step) busy_q <= 1'b0;
    end
  end

  always_comb begin
    wr.en   = busy_q;
    wr.priv = 1'b1;
    if (last_step) begin
      wr.ofs  = 1'b0;
      wr.data = '0;
    end else begin
      wr.ofs  = step_q[0];
      wr.data = step_q[0] ? default_val(item) : default_idx(item);
    end
  end

  assign busy = busy_q;

  AST_INIT_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (step_q <= LAST)); // R5
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_wr_t           wr,
  input  logic              rd_ofs,
  output logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] cur_idx,
  output logic [DATA_W-1:0] func_sel_q,
  output logic [DATA_W-1:0] fdc_q,
  output logic [DATA_W-1:0] lpt_q,
  output logic [DATA_W-1:0] uart_a_q,
  output logic [DATA_W-1:0] uart_b_q
);
  localparam int unsigned DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] regs_q [DEPTH];
  logic [DEPTH-1:0]  wr_sel;
  logic              data_ok;

  assign cur_idx = regs_q[0];
  // data-slot write allowed unless it hits a read-only index from the bus
  assign data_ok = wr.en && wr.ofs && !(is_read_only(cur_idx) && !wr.priv);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    if (g == 0) begin : g_index
      assign wr_sel[g] = (wr.en && !wr.ofs) || (data_ok && (cur_idx == '0));
    end else begin : g_data
      assign wr_sel[g] = data_ok && (cur_idx == DATA_W'(g));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[g] <= '0;
      else if (wr_sel[g]) regs_q[g] <= wr.data;
    end
  end

  always_comb begin
    if (!rd_ofs)             rd_byte = cur_idx;
    else if (cur_idx == '0)  rd_byte = '0;
    else                     rd_byte = regs_q[cur_idx];
  end

  assign func_sel_q = regs_q[IDX_FUNC_SEL];
  assign fdc_q      = regs_q[IDX_FDC];
  assign lpt_q      = regs_q[IDX_LPT];
  assign uart_a_q   = regs_q[IDX_UART_A];
  assign uart_b_q   = regs_q[IDX_UART_B];

  AST_RO_DEVID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && wr.ofs && !wr.priv && cur_idx == IDX_DEV_ID)
      |=> $stable(regs_q[IDX_DEV_ID])); // R4
  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && !wr.ofs) |=> (cur_idx == $past(wr.data))); // R1
  AST_WRSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel)); // R2
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decode_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic [BYTE_W-1:0] io_rdata,
  output logic              init_busy,
  output logic [BYTE_W-1:0] func_sel,
  output logic [BYTE_W-1:0] fdc_base_reg,
  output logic [BYTE_W-1:0] lpt_base_reg,
  output logic [BYTE_W-1:0] uart_a_base_reg,
  output logic [BYTE_W-1:0] uart_b_base_reg,
  output logic [IOB_W-1:0]  fdc_io_base,
  output logic [IOB_W-1:0]  lpt_io_base,
  output logic [IOB_W-1:0]  uart_a_io_base,
  output logic [IOB_W-1:0]  uart_b_io_base
);
  localparam logic [BYTE_W-1:0] IDLE_BYTE = '1;

  logic              bus_hit;
  logic              bus_ofs;
  logic              bus_live;
  cfg_wr_t           seq_wr;
  cfg_wr_t           rf_wr;
  logic [BYTE_W-1:0] rf_rd_byte;
  logic [BYTE_W-1:0] rf_idx;

  sio_cfg_bus_dec #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_dec (
    .io_addr (io_addr),
    .hit     (bus_hit),
    .ofs     (bus_ofs)
  );

  sio_cfg_init_seq #(.NUM_ITEMS(NUM_DEFAULTS)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (init_busy),
    .wr    (seq_wr)
  );

  // bus owns the port only when decoded, enabled and not replaying defaults
  assign bus_live = bus_hit && decode_en && !init_busy;

  always_comb begin
    if (init_busy) begin
      rf_wr = seq_wr;
    end else begin
      rf_wr.en   = io_wr && bus_live;
      rf_wr.ofs  = bus_ofs;
      rf_wr.priv = 1'b0;
      rf_wr.data = io_wdata;
    end
  end

  sio_cfg_regfile #(.DATA_W(BYTE_W)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (rf_wr),
    .rd_ofs     (bus_ofs),
    .rd_byte    (rf_rd_byte),
    .cur_idx    (rf_idx),
    .func_sel_q (func_sel),
    .fdc_q      (fdc_base_reg),
    .lpt_q      (lpt_base_reg),
    .uart_a_q   (uart_a_base_reg),
    .uart_b_q   (uart_b_base_reg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     io_rdata <= IDLE_BYTE;
    else if (io_rd) io_rdata <= bus_live ? rf_rd_byte : IDLE_BYTE;
  end

  assign fdc_io_base    = base_from_reg(fdc_base_reg);
  assign lpt_io_base    = base_from_reg(lpt_base_reg);
  assign uart_a_io_base = base_from_reg(uart_a_base_reg);
  assign uart_b_io_base = base_from_reg(uart_b_base_reg);

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata)); // R11
  AST_DISABLED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !decode_en) |=> (io_rdata == IDLE_BYTE)); // R7
  AST_BUSY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && init_busy) |=> (io_rdata == IDLE_BYTE)); // R5
  AST_IDX0_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && bus_live && bus_ofs && rf_idx == '0) |=> (io_rdata == '0)); // R3
  AST_INIT_ENDS_IDX0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_busy) |-> (rf_idx == '0)); // R6
endmodule

// File: tb/sio_cfg_port_test.sv
module sio_cfg_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        decode_en = 1'b1;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        init_busy;
  logic [7:0]  func_sel, fdc_base_reg, lpt_base_reg, uart_a_base_reg, uart_b_base_reg;
  logic [9:0]  fdc_io_base, lpt_io_base, uart_a_io_base, uart_b_io_base;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sio_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .init_busy(init_busy), .func_sel(func_sel), .fdc_base_reg(fdc_base_reg),
    .lpt_base_reg(lpt_base_reg), .uart_a_base_reg(uart_a_base_reg),
    .uart_b_base_reg(uart_b_base_reg), .fdc_io_base(fdc_io_base),
    .lpt_io_base(lpt_io_base), .uart_a_io_base(uart_a_io_base),
    .uart_b_io_base(uart_b_io_base)
  );

  typedef struct packed {
    logic        is_wr;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 16'h03F0, 8'h05, 8'h00, 8'd1},  // R1 set index 0x05
    '{1'b1, 16'h03F1, 8'hA7, 8'h00, 8'd2},  // R2 store 0xA7
    '{1'b0, 16'h03F1, 8'h00, 8'hA7, 8'd2},  // R2 read back
    '{1'b0, 16'h03F0, 8'h00, 8'h05, 8'd1},  // R1 index read back
    '{1'b1, 16'h03F0, 8'h00, 8'h00, 8'd3},  // R3 index 0
    '{1'b0, 16'h03F1, 8'h00, 8'h00, 8'd3},  // R3 data read gives zero
    '{1'b1, 16'h03F0, 8'hE0, 8'h00, 8'd4},  // R4 device id
    '{1'b1, 16'h03F1, 8'h11, 8'h00, 8'd4},  // R4 dropped
    '{1'b0, 16'h03F1, 8'h00, 8'h3C, 8'd4},  // R4 still 0x3C
    '{1'b1, 16'h03F0, 8'hE1, 8'h00, 8'd4},  // R4 revision
    '{1'b1, 16'h03F1, 8'h99, 8'h00, 8'd4},  // R4 dropped
    '{1'b0, 16'h03F1, 8'h00, 8'h00, 8'd4},  // R4 still 0x00
    '{1'b1, 16'h03F0, 8'hF3, 8'h00, 8'd10}, // R10 unused index
    '{1'b1, 16'h03F1, 8'h5A, 8'h00, 8'd10}, // R10 store
    '{1'b0, 16'h03F1, 8'h00, 8'h5A, 8'd10}, // R10 read back
    '{1'b0, 16'h03F2, 8'h00, 8'hFF, 8'd8},  // R8 outside port
    '{1'b1, 16'h03F9, 8'h77, 8'h00, 8'd8}   // R8 foreign write
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int busy_cycles;
    @(negedge clk);
    // R5 reset state before release
    check("R5 rdata in reset", {8'h0, io_rdata}, 16'h00FF);
    check("R5 busy in reset", {15'h0, init_busy}, 16'h1);
    do_reset();
    // R5 busy window with bus traffic inside it
    busy_cycles = 0;
    io_addr = 16'h03F0; io_wdata = 8'h55; io_wr = 1'b1; io_rd = 1'b1;
    while (init_busy && busy_cycles < 50) begin
      busy_cycles++;
      @(negedge clk);
      io_wr = 1'b0;
      if (busy_cycles == 1) begin
        check("R5 read during init", {8'h0, io_rdata}, 16'h00FF);
      end
      io_rd = 1'b0;
    end
    check("R5 busy length", 16'(busy_cycles), 16'd13);
    // R6 index back to zero, stray write ignored
    bus_rd(16'h03F0, rd);
    check("R6 index after init", {8'h0, rd}, 16'h0000);
    // R5 defaults through the bus
    begin
      logic [7:0] didx [6] = '{8'hE0, 8'hE2, 8'hE3, 8'hE6, 8'hE7, 8'hE8};
      logic [7:0] dval [6] = '{8'h3C, 8'h03, 8'hFC, 8'hDE, 8'hFE, 8'hBE};
      for (int i = 0; i < 6; i++) begin
        bus_wr(16'h03F0, didx[i]);
        bus_rd(16'h03F1, rd);
        check("R5 default value", {8'h0, rd}, {8'h0, dval[i]});
      end
      bus_wr(16'h03F0, 8'hE4);
      bus_rd(16'h03F1, rd);
      check("R5 cleared register", {8'h0, rd}, 16'h0000);
    end
    // R9 raw and decoded outputs
    check("R9 func_sel", {8'h0, func_sel}, 16'h0003);
    check("R9 fdc base", {6'h0, fdc_io_base}, 16'h03F0);
    check("R9 lpt base", {6'h0, lpt_io_base}, 16'h0378);
    check("R9 uart a base", {6'h0, uart_a_io_base}, 16'h03F8);
    check("R9 uart b base", {6'h0, uart_b_io_base}, 16'h02F8);
    bus_wr(16'h03F0, 8'hE7);
    bus_wr(16'h03F1, 8'h3E);
    check("R9 uart a raw", {8'h0, uart_a_base_reg}, 16'h003E);
    check("R9 uart a rewritten", {6'h0, uart_a_io_base}, 16'(8'h3E * 4));
    check("R9 lpt raw", {8'h0, lpt_base_reg}, 16'h00DE);
    check("R9 fdc raw", {8'h0, fdc_base_reg}, 16'h00FC);
    check("R9 uart b raw", {8'h0, uart_b_base_reg}, 16'h00BE);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].is_wr) bus_wr(VECS[v].addr, VECS[v].data);
      else begin
        bus_rd(VECS[v].addr, rd);
        checks++;
        if (rd !== VECS[v].exp) begin
          fails++;
          $display("FAIL R%0d vector %0d: actual %h expected %h", VECS[v].req, v, rd, VECS[v].exp);
        end
      end
    end
    // R8 foreign write above did not move index or data
    bus_rd(16'h03F1, rd);
    check("R8 data after foreign write", {8'h0, rd}, 16'h005A);
    bus_rd(16'h03F0, rd);
    check("R8 index after foreign write", {8'h0, rd}, 16'h00F3);

    // R3 data write with index 0 moves the index
    bus_wr(16'h03F0, 8'h00);
    bus_wr(16'h03F1, 8'h40);
    bus_rd(16'h03F0, rd);
    check("R3 slot zero shared", {8'h0, rd}, 16'h0040);

    // R7 disabled port
    decode_en = 1'b0;
    bus_rd(16'h03F0, rd);
    check("R7 read disabled", {8'h0, rd}, 16'h00FF);
    bus_wr(16'h03F0, 8'h22);
    bus_wr(16'h03F1, 8'h33);
    decode_en = 1'b1;
    bus_rd(16'h03F0, rd);
    check("R7 index unchanged", {8'h0, rd}, 16'h0040);
    bus_rd(16'h03F1, rd);
    check("R7 data unchanged", {8'h0, rd}, 16'h0000);

    // R11 hold without read
    bus_wr(16'h03F1, 8'h6C);
    bus_rd(16'h03F1, rd);
    bus_wr(16'h03F1, 8'h01);
    repeat (3) @(negedge clk);
    check("R11 rdata held", {8'h0, io_rdata}, 16'h006C);

    // second reset restores defaults
    do_reset();
    while (init_busy) @(negedge clk);
    check("R5 defaults after second reset", {8'h0, uart_a_base_reg}, 16'h00FE);
    finish_run();
  end
endmodule